// File: doc/BRIEF.md
# Octal SPI Flash Command Front End

This block sits behind the byte deserializer of a serial NOR flash slave that supports octal I/O. Each byte received while chip select is low arrives as a one-cycle `rx_valid` strobe. The block treats the first byte of a frame as the opcode. It then gathers the address bytes, the mode byte and the dummy bytes that the command needs, and raises a one-cycle `rd_start` or `pp_start` pulse with the captured address. That pulse hands the rest of the frame over to the array datapath, which lies outside this block.

The block also holds two 8-byte configuration register files, one volatile and one nonvolatile. The address phase of the register-access commands selects the byte. Two values come from these files: an octal-enable flag, taken from bit 5 of configuration byte 0 with the sense inverted, and a dummy-byte count for fast reads. The count is taken from volatile byte 1 and falls back to a default for each command when that byte holds 0x00 or 0x0F. The bytes that the block returns, namely identification bytes and configuration bytes, appear on `tx_byte` for the serializer to shift out.

Top module: `octf_front`

## Requirements
- R1: After reset `octal_en`=0, `wel`=0, `tx_byte`=0x00 and `dummy_cnt`=8. Nonvolatile bytes 0 and 1 read back 0xE7 and 0x1F, nonvolatile bytes 2..7 read 0xFF, and volatile byte 0 reads 0xE7.
- R2: Opcodes 0xFD, 0x8C, 0x7C, 0xCC, 0x84, 0x0C and 0xEC always take 4 address bytes. Opcodes 0x9D, 0x8B, 0xCB, 0x82, 0x0B, 0xEB and the register-access opcodes take 3 address bytes when `addr4_mode`=0 and 4 when it is 1. The address is sent MSB first, and a 3-byte address is zero-extended into `start_addr`.
- R3: The octal output reads 0x8B, 0x8C, 0x7C, 0x9D and 0xFD pulse `rd_start` in the cycle after the last address byte is taken. No dummy bytes are collected, and `rd_start` stays low during the address bytes.
- R4: The octal page programs 0x82 and 0x84 pulse `pp_start` after the last address byte, and `wel` is clear in that same cycle.
- R5: Opcode 0xCC collects one mode byte beyond its 4 address bytes, followed by its dummy bytes, before `rd_start`.
- R6: The fast reads 0x0B, 0x0C, 0xCB, 0xCC, 0xEB and 0xEC collect N dummy bytes, where N is volatile byte 1. When that byte is 0x00 or 0x0F, N is 10 for 0xCB, 0xCC, 0xEB and 0xEC and 8 for 0x0B and 0x0C. `dummy_cnt` shows the N chosen for the current read and never shows 0x0F.
- R7: A configuration write (0x81 for the volatile file, 0xB1 for the nonvolatile file) is taken only while `wel`=1. It sends the address bytes and then one data byte. The byte is stored only when the address is 0..7, and `wel` clears when the data byte arrives.
- R8: A configuration read (0x85 for the volatile file, 0xB5 for the nonvolatile file) collects the address bytes. From then until the end of the frame, `tx_byte` shows the addressed byte, or 0x00 when the address is above 7.
- R9: After every accepted configuration write, including one to an address above 7, `octal_en` becomes the inverse of bit 5 of byte 0 of the file that was written. `octal_en` changes at no other time.
- R10: After opcode 0x9E or 0x9F, `tx_byte` shows 0x2C, then the two device ID bytes (defaults 0x5B and 0x1A), then 0x00. It advances one step on each later byte of the frame.
- R11: Opcode 0x06 sets `wel` and opcode 0x04 clears it.
- R12: While `cs_n`=1, received bytes are ignored. Raising `cs_n` drops any partly collected command, so the next frame begins with an opcode and no start pulse comes from the dropped command.
- R13: `rd_start` and `pp_start` are one-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low; frames a command |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a received byte |
| rx_byte | input | 8 | Received byte |
| addr4_mode | input | 1 | 1 selects 4-byte addressing for the mode-dependent opcodes |
| tx_byte | output | 8 | Byte to shift out in the next byte slot |
| rd_start | output | 1 | Pulse: read data phase begins at `start_addr` |
| pp_start | output | 1 | Pulse: program data phase begins at `start_addr` |
| start_addr | output | 32 | Address captured by the last read or program |
| dummy_cnt | output | 8 | Dummy bytes used by the current read |
| wel | output | 1 | Write-enable latch |
| octal_en | output | 1 | Octal I/O enabled |

## Verification
Two events can land on the same clock edge. One is the final address byte of a command, and the other is chip select rising. The bench drives a `rx_valid` strobe with `cs_n` already high in the very cycle that would have completed an octal read. It then checks that no `rd_start` appears and that the next frame's first byte is decoded as an opcode. A second pairing is a configuration write to address 9 while byte 0 of the other file holds the opposite bit 5. The bench checks that `octal_en` follows the written file and not the last stored byte.

// File: rtl/octf_pkg.sv
// Shared types and helpers for the octal flash command front end.
// Assumes byte-level framing; no lane or DDR detail appears here.
package octf_pkg;

    // Command class produced by the opcode decoder
    typedef enum logic [2:0] {
        K_NONE, K_WREN, K_WRDI, K_ID, K_READ, K_PROG, K_RDCFG, K_WRCFG
    } kind_e;

    // Per-opcode properties
    typedef struct packed {
        kind_e kind;
        logic  force4;   // address is always 4 bytes
        logic  dummy;    // collects configurable dummy bytes
        logic  extra;    // collects one mode byte after the address
        logic  io10;     // fallback dummy count is the I/O value
        logic  nv;       // register access targets the nonvolatile file
    } cmd_t;

    // Sequencer states
    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_WAIT, S_WDATA, S_CFGRD, S_ID, S_SINK
    } state_e;

    localparam logic [7:0] DUMMY_IO_DFLT    = 8'd10;
    localparam logic [7:0] DUMMY_OTHER_DFLT = 8'd8;

    // Dummy count with fallback when the config field holds 0x00 or 0x0F
    function automatic logic [7:0] dummy_bytes(input logic [7:0] field,
                                               input logic io10);
        if (field == 8'h00 || field == 8'h0F)
            return io10 ? DUMMY_IO_DFLT : DUMMY_OTHER_DFLT;
        return field;
    endfunction

endpackage

// File: rtl/octf_decode.sv
// Opcode decoder: classifies one received opcode byte.
// Purely combinational; unknown opcodes map to K_NONE.
module octf_decode
    import octf_pkg::*;
(
    input  logic [7:0] op,
    output cmd_t       cmd
);

    // Opcode table lookup
    always_comb begin
        cmd = '0;
        cmd.kind = K_NONE;
        case (op)
            8'h06: cmd.kind = K_WREN;
            8'h04: cmd.kind = K_WRDI;
            8'h9E, 8'h9F: cmd.kind = K_ID;
            // octal output reads: address only
            8'h8B, 8'h9D: cmd.kind = K_READ;
            8'h8C, 8'h7C, 8'hFD: begin
                cmd.kind   = K_READ;
                cmd.force4 = 1'b1;
            end
            // fast reads with dummy bytes
            8'h0B: begin
                cmd.kind  = K_READ;
                cmd.dummy = 1'b1;
            end
            8'h0C: begin
                cmd.kind   = K_READ;
                cmd.dummy  = 1'b1;
                cmd.force4 = 1'b1;
            end
            8'hCB, 8'hEB: begin
                cmd.kind  = K_READ;
                cmd.dummy = 1'b1;
                cmd.io10  = 1'b1;
            end
            8'hEC: begin
                cmd.kind   = K_READ;
                cmd.dummy  = 1'b1;
                cmd.io10   = 1'b1;
                cmd.force4 = 1'b1;
            end
            8'hCC: begin
                cmd.kind   = K_READ;
                cmd.dummy  = 1'b1;
                cmd.io10   = 1'b1;
                cmd.force4 = 1'b1;
                cmd.extra  = 1'b1;
            end
            // octal page programs
            8'h82: cmd.kind = K_PROG;
            8'h84: begin
                cmd.kind   = K_PROG;
                cmd.force4 = 1'b1;
            end
            // configuration register access
            8'h85: cmd.kind = K_RDCFG;
            8'h81: cmd.kind = K_WRCFG;
            8'hB5: begin
                cmd.kind = K_RDCFG;
                cmd.nv   = 1'b1;
            end
            8'hB1: begin
                cmd.kind = K_WRCFG;
                cmd.nv   = 1'b1;
            end
            default: cmd.kind = K_NONE;
        endcase
    end

endmodule

// File: rtl/octf_cfg_regs.sv
// Volatile and nonvolatile configuration register files.
// Writes land only in range; every write strobe recomputes the octal
// flag from byte 0 of the file written. Reads above range return 0.
module octf_cfg_regs #(
    parameter int         NBYTES   = 8,
    parameter int         OCT_BIT  = 5,
    parameter logic [7:0] NV0_RST  = 8'hE7,
    parameter logic [7:0] NV1_RST  = 8'h1F,
    parameter logic [7:0] NVX_RST  = 8'hFF,
    parameter logic [7:0] VOL0_RST = 8'hE7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_nv,
    input  logic [31:0] wr_addr,
    input  logic [7:0]  wr_data,
    input  logic        rd_nv,
    input  logic [31:0] rd_addr,
    output logic [7:0]  rd_data,
    output logic [7:0]  dummy_field,
    output logic        octal_en
);

    localparam int AW = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    logic [7:0]        vol_q [NBYTES];
    logic [7:0]        nv_q  [NBYTES];
    logic [NBYTES-1:0] hit;
    logic              wr_ok;
    logic              rd_ok;
    logic [7:0]        new_b0;

    assign wr_ok = (wr_addr < 32'(NBYTES));
    assign rd_ok = (rd_addr < 32'(NBYTES));

    // Per-byte write select
    genvar gi;
    generate
        for (gi = 0; gi < NBYTES; gi++) begin : g_hit
            assign hit[gi] = wr_en && wr_ok && (wr_addr[AW-1:0] == AW'(gi));
        end
    endgenerate

    // Byte 0 of the written file as it stands after this write
    always_comb begin
        if (hit[0])
            new_b0 = wr_data;
        else
            new_b0 = wr_nv ? nv_q[0] : vol_q[0];
    end

    // Register files and octal flag update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBYTES; i++) begin
                vol_q[i] <= (i == 0) ? VOL0_RST : 8'h00;
                nv_q[i]  <= (i == 0) ? NV0_RST : (i == 1) ? NV1_RST : NVX_RST;
            end
            octal_en <= ~NV0_RST[OCT_BIT];
        end else if (wr_en) begin
            for (int i = 0; i < NBYTES; i++) begin
                if (hit[i] && wr_nv)  nv_q[i]  <= wr_data;
                if (hit[i] && !wr_nv) vol_q[i] <= wr_data;
            end
            octal_en <= ~new_b0[OCT_BIT];
        end
    end

    // Read mux
    always_comb begin
        rd_data = 8'h00;
        if (rd_ok)
            rd_data = rd_nv ? nv_q[rd_addr[AW-1:0]] : vol_q[rd_addr[AW-1:0]];
    end

    assign dummy_field = vol_q[1];

endmodule

// File: rtl/octf_seq.sv
// Frame sequencer: opcode, address, mode/dummy and data phases.
// Assumes rx_valid is a one-cycle strobe per byte; cs_n high aborts.
module octf_seq
    import octf_pkg::*;
#(
    parameter logic [7:0] ID_MFR  = 8'h2C,
    parameter logic [7:0] ID_TYPE = 8'h5B,
    parameter logic [7:0] ID_CAP  = 8'h1A
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        addr4_mode,
    input  cmd_t        cmd,
    input  logic [7:0]  dummy_field,
    input  logic [7:0]  cfg_rd_data,
    output logic [7:0]  tx_byte,
    output logic        rd_start,
    output logic        pp_start,
    output logic [31:0] start_addr,
    output logic [7:0]  dummy_cnt,
    output logic        wel,
    output logic        cfg_wr,
    output logic        cfg_nv,
    output logic [31:0] cfg_addr,
    output logic [7:0]  cfg_wr_data
);

    state_e      state;
    kind_e       cur_kind;
    logic        cur_nv;
    logic        cur_dummy;
    logic        cur_extra;
    logic [2:0]  alen_q;
    logic [31:0] addr_q;
    logic [8:0]  cnt;
    logic [1:0]  id_idx;
    logic [31:0] addr_nxt;
    logic [8:0]  wait_tot;
    logic        take;
    logic        addr_last;

    assign take      = rx_valid && !cs_n;
    assign addr_nxt  = {addr_q[23:0], rx_byte};
    assign addr_last = (cnt == ({6'd0, alen_q} - 9'd1));

    // Bytes still owed after the address of a read
    always_comb begin
        wait_tot = {8'd0, cur_extra};
        if (cur_dummy)
            wait_tot = wait_tot + {1'b0, dummy_cnt};
    end

    // Main phase sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            cur_kind   <= K_NONE;
            cur_nv     <= 1'b0;
            cur_dummy  <= 1'b0;
            cur_extra  <= 1'b0;
            alen_q     <= 3'd3;
            addr_q     <= '0;
            cnt        <= '0;
            id_idx     <= '0;
            wel        <= 1'b0;
            rd_start   <= 1'b0;
            pp_start   <= 1'b0;
            start_addr <= '0;
            dummy_cnt  <= DUMMY_OTHER_DFLT;
        end else begin
            rd_start <= 1'b0;
            pp_start <= 1'b0;
            if (cs_n) begin
                state  <= S_IDLE;
                cnt    <= '0;
                id_idx <= '0;
            end else if (rx_valid) begin
                case (state)
                    S_IDLE: begin
                        cur_kind  <= cmd.kind;
                        cur_nv    <= cmd.nv;
                        cur_dummy <= cmd.dummy;
                        cur_extra <= cmd.extra;
                        alen_q    <= (cmd.force4 || addr4_mode) ? 3'd4 : 3'd3;
                        addr_q    <= '0;
                        cnt       <= '0;
                        id_idx    <= '0;
                        case (cmd.kind)
                            K_WREN: begin
                                wel   <= 1'b1;
                                state <= S_SINK;
                            end
                            K_WRDI: begin
                                wel   <= 1'b0;
                                state <= S_SINK;
                            end
                            K_ID:  state <= S_ID;
                            K_READ: begin
                                dummy_cnt <= cmd.dummy ? dummy_bytes(dummy_field, cmd.io10)
                                                       : 8'd0;
                                state     <= S_ADDR;
                            end
                            K_PROG, K_RDCFG: state <= S_ADDR;
                            K_WRCFG: state <= wel ? S_ADDR : S_SINK;
                            default: state <= S_SINK;
                        endcase
                    end
                    S_ADDR: begin
                        addr_q <= addr_nxt;
                        cnt    <= cnt + 9'd1;
                        if (addr_last) begin
                            case (cur_kind)
                                K_READ: begin
                                    start_addr <= addr_nxt;
                                    if (wait_tot == 9'd0) begin
                                        rd_start <= 1'b1;
                                        state    <= S_SINK;
                                    end else begin
                                        cnt   <= wait_tot;
                                        state <= S_WAIT;
                                    end
                                end
                                K_PROG: begin
                                    start_addr <= addr_nxt;
                                    pp_start   <= 1'b1;
                                    wel        <= 1'b0;
                                    state      <= S_SINK;
                                end
                                K_RDCFG: state <= S_CFGRD;
                                K_WRCFG: state <= S_WDATA;
                                default: state <= S_SINK;
                            endcase
                        end
                    end
                    S_WAIT: begin
                        if (cnt == 9'd1) begin
                            rd_start <= 1'b1;
                            state    <= S_SINK;
                        end else begin
                            cnt <= cnt - 9'd1;
                        end
                    end
                    S_WDATA: begin
                        wel   <= 1'b0;
                        state <= S_SINK;
                    end
                    S_ID: begin
                        if (id_idx != 2'd3)
                            id_idx <= id_idx + 2'd1;
                    end
                    default: state <= state;
                endcase
            end
        end
    end

    // Configuration file access driven from the latched command
    assign cfg_wr      = take && (state == S_WDATA);
    assign cfg_nv      = cur_nv;
    assign cfg_addr    = addr_q;
    assign cfg_wr_data = rx_byte;

    // Outgoing byte selection
    always_comb begin
        tx_byte = 8'h00;
        if (state == S_ID) begin
            case (id_idx)
                2'd0:    tx_byte = ID_MFR;
                2'd1:    tx_byte = ID_TYPE;
                2'd2:    tx_byte = ID_CAP;
                default: tx_byte = 8'h00;
            endcase
        end else if (state == S_CFGRD) begin
            tx_byte = cfg_rd_data;
        end
    end

endmodule

// File: rtl/octf_front.sv
// Top of the octal flash command front end: decoder, sequencer and
// configuration files. Byte-level; lanes and array are elsewhere.
module octf_front #(
    parameter int         CFG_BYTES = 8,
    parameter int         OCT_BIT   = 5,
    parameter logic [7:0] NV0_RST   = 8'hE7,
    parameter logic [7:0] NV1_RST   = 8'h1F,
    parameter logic [7:0] ID_MFR    = 8'h2C,
    parameter logic [7:0] ID_TYPE   = 8'h5B,
    parameter logic [7:0] ID_CAP    = 8'h1A
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        addr4_mode,
    output logic [7:0]  tx_byte,
    output logic        rd_start,
    output logic        pp_start,
    output logic [31:0] start_addr,
    output logic [7:0]  dummy_cnt,
    output logic        wel,
    output logic        octal_en
);

    octf_pkg::cmd_t cmd;
    logic        cfg_wr;
    logic        cfg_nv;
    logic [31:0] cfg_addr;
    logic [7:0]  cfg_wr_data;
    logic [7:0]  cfg_rd_data;
    logic [7:0]  dummy_field;

    octf_decode u_dec (
        .op  (rx_byte),
        .cmd (cmd)
    );

    octf_seq #(
        .ID_MFR  (ID_MFR),
        .ID_TYPE (ID_TYPE),
        .ID_CAP  (ID_CAP)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .rx_valid    (rx_valid),
        .rx_byte     (rx_byte),
        .addr4_mode  (addr4_mode),
        .cmd         (cmd),
        .dummy_field (dummy_field),
        .cfg_rd_data (cfg_rd_data),
        .tx_byte     (tx_byte),
        .rd_start    (rd_start),
        .pp_start    (pp_start),
        .start_addr  (start_addr),
        .dummy_cnt   (dummy_cnt),
        .wel         (wel),
        .cfg_wr      (cfg_wr),
        .cfg_nv      (cfg_nv),
        .cfg_addr    (cfg_addr),
        .cfg_wr_data (cfg_wr_data)
    );

    octf_cfg_regs #(
        .NBYTES   (CFG_BYTES),
        .OCT_BIT  (OCT_BIT),
        .NV0_RST  (NV0_RST),
        .NV1_RST  (NV1_RST),
        .NVX_RST  (8'hFF),
        .VOL0_RST (NV0_RST)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_wr),
        .wr_nv       (cfg_nv),
        .wr_addr     (cfg_addr),
        .wr_data     (cfg_wr_data),
        .rd_nv       (cfg_nv),
        .rd_addr     (cfg_addr),
        .rd_data     (cfg_rd_data),
        .dummy_field (dummy_field),
        .octal_en    (octal_en)
    );

endmodule

// File: rtl/octf_chk.sv
// Protocol checker for octf_front, bound to every instance.
module octf_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       rx_valid,
    input logic [7:0] rx_byte,
    input logic       rd_start,
    input logic       pp_start,
    input logic       wel,
    input logic       octal_en,
    input logic       cfg_wr,
    input logic [7:0] dummy_cnt
);

    // R13
    start_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_start && pp_start));

    // R13
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> !rd_start);

    // R12
    cs_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !(rd_start || pp_start));

    // R4
    pp_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pp_start |-> !wel);

    // R9
    oct_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(octal_en) |-> $past(cfg_wr));

    // R11
    wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(rx_valid && !cs_n && rx_byte == 8'h06));

    // R6
    dummy_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dummy_cnt != 8'h0F);

endmodule

bind octf_front octf_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .rd_start  (rd_start),
    .pp_start  (pp_start),
    .wel       (wel),
    .octal_en  (octal_en),
    .cfg_wr    (cfg_wr),
    .dummy_cnt (dummy_cnt)
);

// File: tb/octf_front_tb.sv
// Self-checking bench for octf_front: directed corners plus seeded
// random configuration traffic and fast reads against a bench model.
module octf_front_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        addr4_mode = 1'b0;
    logic [7:0]  tx_byte;
    logic        rd_start;
    logic        pp_start;
    logic [31:0] start_addr;
    logic [7:0]  dummy_cnt;
    logic        wel;
    logic        octal_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] m_nv  [8];
    logic [7:0] m_vol [8];
    logic       m_oct;

    octf_front u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .addr4_mode(addr4_mode), .tx_byte(tx_byte),
        .rd_start(rd_start), .pp_start(pp_start), .start_addr(start_addr),
        .dummy_cnt(dummy_cnt), .wel(wel), .octal_en(octal_en)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic cs_begin();
        @(negedge clk);
        cs_n = 1'b0;
    endtask

    task automatic cs_end();
        @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_addr(input logic [31:0] a, input int n);
        for (int i = n - 1; i >= 0; i--) send(a[i*8 +: 8]);
    endtask

    function automatic logic [7:0] exp_dummy(input logic [7:0] f, input logic [7:0] op);
        bit io = (op == 8'hCB || op == 8'hCC || op == 8'hEB || op == 8'hEC);
        if (f == 8'h00 || f == 8'h0F) return io ? 8'd10 : 8'd8;
        return f;
    endfunction

    // Configuration write with the model kept in step (3-byte address)
    task automatic wr_cfg(input bit nv, input logic [7:0] a, input logic [7:0] d,
                          input bit do_wren);
        if (do_wren) begin
            cs_begin(); send(8'h06); cs_end();
        end
        cs_begin();
        send(nv ? 8'hB1 : 8'h81);
        send_addr({24'd0, a}, 3);
        send(d);
        cs_end();
        if (do_wren) begin
            if (a < 8) begin
                if (nv) m_nv[a[2:0]] = d; else m_vol[a[2:0]] = d;
            end
            m_oct = nv ? ~m_nv[0][5] : ~m_vol[0][5];
        end
    endtask

    task automatic rd_cfg(input bit nv, input logic [7:0] a, output logic [7:0] v);
        cs_begin();
        send(nv ? 8'hB5 : 8'h85);
        send_addr({24'd0, a}, 3);
        v = tx_byte;
        cs_end();
    endtask

    // Run a read; report bytes sent after the address until rd_start
    task automatic run_read(input logic [7:0] op, input logic [31:0] a, input int n,
                            output int waited, output bit early);
        early = 1'b0;
        cs_begin();
        send(op);
        for (int i = n - 1; i >= 0; i--) begin
            send(a[i*8 +: 8]);
            if (i != 0 && rd_start) early = 1'b1;
        end
        waited = 0;
        while (!rd_start && waited < 400) begin
            send(8'hA5);
            waited++;
        end
        cs_end();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int  w;
        bit  early;
        void'($urandom(32'h0C7A_1234));
        m_nv  = '{8'hE7, 8'h1F, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
        m_vol = '{8'hE7, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        m_oct = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(octal_en == 1'b0, "R1 octal_en", 32'(octal_en), 0);
        chk(wel == 1'b0, "R1 wel", 32'(wel), 0);
        chk(tx_byte == 8'h00, "R1 tx_byte", 32'(tx_byte), 0);
        chk(dummy_cnt == 8'd8, "R1 dummy_cnt", 32'(dummy_cnt), 8);
        rd_cfg(1'b1, 8'd0, v); chk(v == 8'hE7, "R1 nv0", 32'(v), 32'hE7);
        rd_cfg(1'b1, 8'd1, v); chk(v == 8'h1F, "R1 nv1", 32'(v), 32'h1F);
        rd_cfg(1'b0, 8'd0, v); chk(v == 8'hE7, "R1 vol0", 32'(v), 32'hE7);

        // R8 repeated byte and out-of-range read
        cs_begin(); send(8'hB5); send_addr(32'd1, 3);
        send(8'h00); send(8'h00);
        chk(tx_byte == 8'h1F, "R8 repeat", 32'(tx_byte), 32'h1F);
        cs_end();
        rd_cfg(1'b1, 8'd9, v); chk(v == 8'h00, "R8 addr>7", 32'(v), 0);

        // R10 identification bytes
        cs_begin(); send(8'h9E);
        chk(tx_byte == 8'h2C, "R10 mfr", 32'(tx_byte), 32'h2C);
        send(8'h00); chk(tx_byte == 8'h5B, "R10 id1", 32'(tx_byte), 32'h5B);
        send(8'h00); chk(tx_byte == 8'h1A, "R10 id2", 32'(tx_byte), 32'h1A);
        send(8'h00); chk(tx_byte == 8'h00, "R10 tail", 32'(tx_byte), 0);
        cs_end();

        // R11 latch set and clear
        cs_begin(); send(8'h06); cs_end();
        chk(wel == 1'b1, "R11 set", 32'(wel), 1);
        cs_begin(); send(8'h04); cs_end();
        chk(wel == 1'b0, "R11 clear", 32'(wel), 0);

        // R7 write without latch is dropped
        wr_cfg(1'b1, 8'd0, 8'hC7, 1'b0);
        rd_cfg(1'b1, 8'd0, v); chk(v == 8'hE7, "R7 no wel", 32'(v), 32'hE7);
        chk(octal_en == 1'b0, "R7 no wel oct", 32'(octal_en), 0);

        // R9/R7 volatile write enabling octal
        wr_cfg(1'b0, 8'd0, 8'hC7, 1'b1);
        chk(octal_en == 1'b1, "R9 vol0 bit5 clear", 32'(octal_en), 1);
        chk(wel == 1'b0, "R7 wel cleared", 32'(wel), 0);
        rd_cfg(1'b0, 8'd0, v); chk(v == 8'hC7, "R7 stored", 32'(v), 32'hC7);
        // R9 out-of-range write recomputes from the nonvolatile file
        wr_cfg(1'b1, 8'd9, 8'h00, 1'b1);
        chk(octal_en == 1'b0, "R9 nv recompute", 32'(octal_en), 0);
        rd_cfg(1'b1, 8'd1, v); chk(v == 8'h1F, "R7 addr>7 not stored", 32'(v), 32'h1F);

        // R3/R2 octal output reads
        run_read(8'h8B, 32'h00123456, 3, w, early);
        chk(w == 0 && !early, "R3 0x8B no dummy", 32'(w), 0);
        chk(start_addr == 32'h00123456, "R2 3-byte addr", start_addr, 32'h00123456);
        run_read(8'h7C, 32'h89ABCDEF, 4, w, early);
        chk(w == 0 && !early, "R3 0x7C", 32'(w), 0);
        chk(start_addr == 32'h89ABCDEF, "R2 forced 4-byte", start_addr, 32'h89ABCDEF);
        addr4_mode = 1'b1;
        run_read(8'h9D, 32'h01020304, 4, w, early);
        chk(w == 0 && !early && start_addr == 32'h01020304, "R2 addr4_mode", start_addr,
            32'h01020304);
        addr4_mode = 1'b0;

        // R4 program clears latch
        cs_begin(); send(8'h06); cs_end();
        cs_begin(); send(8'h84); send_addr(32'h00000100, 4);
        chk(pp_start == 1'b1, "R4 pp_start", 32'(pp_start), 1);
        chk(wel == 1'b0, "R4 wel", 32'(wel), 0);
        chk(start_addr == 32'h100, "R4 addr", start_addr, 32'h100);
        cs_end();

        // R6 default dummies, R5 mode byte
        run_read(8'h0B, 32'h10, 3, w, early);
        chk(w == 8 && dummy_cnt == 8'd8, "R6 0x0B default", 32'(w), 8);
        run_read(8'hEB, 32'h10, 3, w, early);
        chk(w == 10, "R6 0xEB default", 32'(w), 10);
        run_read(8'hCC, 32'h10, 4, w, early);
        chk(w == 11, "R5 0xCC mode+dummy", 32'(w), 11);

        // R12 abort mid-address and same-cycle chip select rise
        cs_begin(); send(8'h8B); send(8'h00); send(8'h00); cs_end();
        cs_begin(); send(8'h06); cs_end();
        chk(wel == 1'b1, "R12 new opcode after abort", 32'(wel), 1);
        cs_begin(); send(8'h04); cs_end();
        cs_begin(); send(8'h8B); send(8'h00); send(8'h00);
        @(negedge clk); cs_n = 1'b1; rx_valid = 1'b1; rx_byte = 8'h00;
        @(negedge clk); rx_valid = 1'b0;
        chk(rd_start == 1'b0, "R12 same-cycle cs rise", 32'(rd_start), 0);
        @(negedge clk);
        chk(rd_start == 1'b0 && pp_start == 1'b0, "R13 no late pulse", 32'(rd_start), 0);

        // R6 random dummy fields and fast-read opcodes
        for (int k = 0; k < 16; k++) begin
            logic [7:0] f;
            logic [7:0] op;
            logic [7:0] ops [6];
            int n;
            ops = '{8'h0B, 8'h0C, 8'hCB, 8'hCC, 8'hEB, 8'hEC};
            case ($urandom_range(0, 3))
                0: f = 8'h00;
                1: f = 8'h0F;
                default: f = 8'($urandom_range(1, 20));
            endcase
            wr_cfg(1'b0, 8'd1, f, 1'b1);
            op = ops[$urandom_range(0, 5)];
            n = (op == 8'h0C || op == 8'hCC || op == 8'hEC) ? 4 : 3;
            run_read(op, $urandom, n, w, early);
            chk(w == int'(exp_dummy(f, op)) + ((op == 8'hCC) ? 1 : 0) && !early,
                "R6 random dummy", 32'(w), 32'(exp_dummy(f, op)));
            chk(dummy_cnt == exp_dummy(f, op), "R6 dummy_cnt", 32'(dummy_cnt),
                32'(exp_dummy(f, op)));
        end

        // R7/R8/R9 random configuration traffic
        for (int k = 0; k < 24; k++) begin
            bit nv;
            logic [7:0] a;
            logic [7:0] d;
            logic [7:0] e;
            nv = 1'($urandom_range(0, 1));
            a  = 8'($urandom_range(0, 9));
            d  = 8'($urandom);
            wr_cfg(nv, a, d, 1'($urandom_range(0, 3) != 0));
            chk(octal_en == m_oct, "R9 random oct", 32'(octal_en), 32'(m_oct));
            a = 8'($urandom_range(0, 9));
            rd_cfg(nv, a, v);
            e = (a < 8) ? (nv ? m_nv[a[2:0]] : m_vol[a[2:0]]) : 8'h00;
            chk(v == e, "R8 random read", 32'(v), 32'(e));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule